// File: doc/BRIEF.md
# Channel Page Register and Transfer Address Generator

This block keeps two page bytes, a low one and a high one, for each of four transfer channels, and builds the wide physical memory address for the channel that is moving data. An 8-bit register port lets software write and read the page bytes. The port offset maps to a channel through a fixed, irregular table. The high page bank can be left out with a parameter. The block takes in the channel's current 16-bit address. It outputs the composed physical address and the neighbouring address that the next unit will use. The step direction comes from one bit of the channel's mode byte.

The block also keeps a position counter for each channel. Each transfer-step strobe moves the counter on by one unit, scaled by the controller's width shift. When the counter reaches the programmed base count plus one, scaled by the same shift, the block raises a one-clock terminal-count pulse and returns that channel's counter to zero. The pulse comes from a two-state machine. State TRK_IDLE moves to TRK_TERM on a step that hits the limit. TRK_TERM stays in TRK_TERM on another hit and otherwise goes back to TRK_IDLE. The pulse is high exactly while the machine is in TRK_TERM.

Top module: `pagegen_top`

## Requirements
- R1: Page port offsets select channels by their low 3 bits: offset 1 is channel 2, offset 2 is channel 3, offset 3 is channel 1 and offset 7 is channel 0.
- R2: Offsets 0, 4, 5 and 6 are unmapped. A write there changes no page byte, and a read there returns 0x00.
- R3: A write to a mapped offset stores the byte. `io_hi_sel`=0 selects the low bank and 1 selects the high bank. A read of the same offset and bank returns the stored byte.
- R4: `phys_addr` equals {high page bits 6..0, low page byte, `cur_addr`} for the channel given by `xfer_chan`. Bit 7 of the high page never appears in it.
- R5: With HIGH_EN=0, high-bank writes have no effect, high-bank reads return 0x00 and the top 7 bits of `phys_addr` are 0.
- R6: `next_addr` is `cur_addr`-1 when bit 5 of `chan_mode` is 1 and `cur_addr`+1 when it is 0, modulo 2^16. The other mode bits have no effect.
- R7: Each step adds 1<<`wide_shift` to the selected channel's position. When the new position equals (`base_count`+1)<<`wide_shift`, the position returns to 0 and a terminal count is flagged.
- R8: `tc_pulse` is registered. It is high for one clock, the cycle after the clock edge that took the hitting step, and `tc_chan` then names that channel. Each channel keeps its own position.
- R9: After reset every page byte and every position is 0 and `tc_pulse` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Page port write strobe |
| io_hi_sel | input | 1 | 1 selects the high page bank, 0 the low bank |
| io_offset | input | 3 | Page port offset |
| io_wdata | input | 8 | Page port write byte |
| io_rdata | output | 8 | Page port read byte (combinational) |
| xfer_chan | input | 2 | Channel being transferred |
| cur_addr | input | 16 | Current address of that channel |
| chan_mode | input | 8 | Mode byte of that channel; bit 5 sets direction |
| wide_shift | input | 1 | Width shift: 0 for byte units, 1 for word units |
| base_count | input | 16 | Programmed base count of that channel |
| xfer_step | input | 1 | One unit transferred on `xfer_chan` |
| phys_addr | output | 31 | Composed physical address |
| next_addr | output | 16 | Address for the following unit |
| tc_pulse | output | 1 | Terminal-count pulse |
| tc_chan | output | 2 | Channel of the latest terminal count |

## Verification
The bench writes a distinct byte through every mapped offset. It then reads each channel's physical address, so a swapped table entry shows up as the wrong page byte on the wrong channel. It writes into the unmapped offsets and then reads every mapped byte back, which catches a decoder that aliases offsets. It stores 0xFF in a high page to catch a design that lets bit 7 leak into the address. It checks address wrap in both directions at 0x0000 and 0xFFFF. Transfers on two channels are interleaved, with both width shifts and with a base count of zero. A design that shares one position counter, fails to scale the limit, or fails to clear the position after a hit would pulse early, late or on the wrong channel.

// File: rtl/pagegen_pkg.sv
package pagegen_pkg;
    localparam int PG_CH   = 4;
    localparam int PG_CH_W = $clog2(PG_CH);

    typedef enum logic [0:0] {TRK_IDLE, TRK_TERM} trk_state_t;

    typedef struct packed {
        logic               hit;
        logic [PG_CH_W-1:0] chan;
    } chan_pick_t;

    // Irregular offset-to-channel table; unmapped offsets report hit = 0.
    function automatic chan_pick_t decode_offset(input logic [2:0] off);
        chan_pick_t p;
        unique case (off)
            3'd1:    p = '{hit: 1'b1, chan: PG_CH_W'(2)};
            3'd2:    p = '{hit: 1'b1, chan: PG_CH_W'(3)};
            3'd3:    p = '{hit: 1'b1, chan: PG_CH_W'(1)};
            3'd7:    p = '{hit: 1'b1, chan: PG_CH_W'(0)};
            default: p = '{hit: 1'b0, chan: '0};
        endcase
        return p;
    endfunction
endpackage

// File: rtl/pagegen_regfile.sv
module pagegen_regfile
    import pagegen_pkg::*;
#(
    parameter int PAGE_W  = 8,
    parameter bit HIGH_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic               io_hi_sel,
    input  logic [2:0]         io_offset,
    input  logic [PAGE_W-1:0]  io_wdata,
    output logic [PAGE_W-1:0]  io_rdata,
    input  logic [PG_CH_W-1:0] sel_chan,
    output logic [PAGE_W-1:0]  low_sel,
    output logic [PAGE_W-1:0]  high_sel
);
    chan_pick_t pick;
    logic [PG_CH-1:0][PAGE_W-1:0] low_q;
    logic [PAGE_W-1:0] high_rd;

    assign pick = decode_offset(io_offset);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
        end else if (io_wr && !io_hi_sel && pick.hit) begin
            low_q[pick.chan] <= io_wdata;
        end
    end

    generate
        if (HIGH_EN) begin : g_high
            logic [PG_CH-1:0][PAGE_W-1:0] high_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    high_q <= '0;
                end else if (io_wr && io_hi_sel && pick.hit) begin
                    high_q[pick.chan] <= io_wdata;
                end
            end
            assign high_sel = high_q[sel_chan];
            assign high_rd  = high_q[pick.chan];
        end else begin : g_nohigh
            assign high_sel = '0;
            assign high_rd  = '0;
        end
    endgenerate

    assign low_sel  = low_q[sel_chan];
    assign io_rdata = !pick.hit ? '0 : (io_hi_sel ? high_rd : low_q[pick.chan]);

    // R2: writes to unmapped offsets leave the low bank untouched
    a_r2_unmapped_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !pick.hit) |=> $stable(low_q));

    // R3: a mapped low write lands in the decoded channel
    a_r3_low_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && !io_hi_sel && pick.hit) |=> (low_q[$past(pick.chan)] == $past(io_wdata)));
endmodule

// File: rtl/pagegen_stepper.sv
module pagegen_stepper #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 8,
    parameter int HIGH_KEEP = 7,
    parameter int DIR_BIT   = 5,
    localparam int PHYS_W   = HIGH_KEEP + PAGE_W + ADDR_W
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [7:0]        chan_mode,
    input  logic [PAGE_W-1:0] low_page,
    input  logic [PAGE_W-1:0] high_page,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [ADDR_W-1:0] next_addr
);
    logic dir_down;

    assign dir_down  = chan_mode[DIR_BIT];
    assign next_addr = dir_down ? cur_addr - ADDR_W'(1) : cur_addr + ADDR_W'(1);
    assign phys_addr = {high_page[HIGH_KEEP-1:0], low_page, cur_addr};
endmodule

// File: rtl/pagegen_tracker.sv
module pagegen_tracker
    import pagegen_pkg::*;
#(
    parameter int CNT_W  = 16,
    localparam int POS_W = CNT_W + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xfer_step,
    input  logic [PG_CH_W-1:0] xfer_chan,
    input  logic               wide_shift,
    input  logic [CNT_W-1:0]   base_count,
    output logic               tc_pulse,
    output logic [PG_CH_W-1:0] tc_chan
);
    logic [PG_CH-1:0][POS_W-1:0] pos_q;
    logic [POS_W-1:0] stride, limit, pos_next;
    logic hit;
    trk_state_t state_q, state_d;

    assign stride   = wide_shift ? POS_W'(2) : POS_W'(1);
    assign limit    = (POS_W'(base_count) + POS_W'(1)) << wide_shift;
    assign pos_next = pos_q[xfer_chan] + stride;
    assign hit      = xfer_step && (pos_next == limit);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (xfer_step) begin
            pos_q[xfer_chan] <= hit ? '0 : pos_next;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tc_chan <= '0;
        end else if (hit) begin
            tc_chan <= xfer_chan;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: if (hit) state_d = TRK_TERM;
            TRK_TERM: state_d = hit ? TRK_TERM : TRK_IDLE;
            default:  state_d = TRK_IDLE;
        endcase
    end

    always_comb begin
        tc_pulse = 1'b0;
        unique case (state_q)
            TRK_IDLE: tc_pulse = 1'b0;
            TRK_TERM: tc_pulse = 1'b1;
            default:  tc_pulse = 1'b0;
        endcase
    end

    // R8: a pulse only ever follows a step
    a_r8_pulse_after_step: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> $past(xfer_step));

    // R8: the reported channel only moves together with a pulse
    a_r8_chan_moves_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tc_chan) |-> tc_pulse);
endmodule

// File: rtl/pagegen_top.sv
module pagegen_top
    import pagegen_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 8,
    parameter int HIGH_KEEP = 7,
    parameter int CNT_W     = 16,
    parameter bit HIGH_EN   = 1'b1,
    localparam int PHYS_W   = HIGH_KEEP + PAGE_W + ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_wr,
    input  logic               io_hi_sel,
    input  logic [2:0]         io_offset,
    input  logic [PAGE_W-1:0]  io_wdata,
    output logic [PAGE_W-1:0]  io_rdata,
    input  logic [PG_CH_W-1:0] xfer_chan,
    input  logic [ADDR_W-1:0]  cur_addr,
    input  logic [7:0]         chan_mode,
    input  logic               wide_shift,
    input  logic [CNT_W-1:0]   base_count,
    input  logic               xfer_step,
    output logic [PHYS_W-1:0]  phys_addr,
    output logic [ADDR_W-1:0]  next_addr,
    output logic               tc_pulse,
    output logic [PG_CH_W-1:0] tc_chan
);
    logic [PAGE_W-1:0] low_sel, high_sel;

    pagegen_regfile #(.PAGE_W(PAGE_W), .HIGH_EN(HIGH_EN)) u_regs (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_hi_sel(io_hi_sel),
        .io_offset(io_offset), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .sel_chan(xfer_chan), .low_sel(low_sel), .high_sel(high_sel)
    );

    pagegen_stepper #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .HIGH_KEEP(HIGH_KEEP)) u_step (
        .cur_addr(cur_addr), .chan_mode(chan_mode), .low_page(low_sel),
        .high_page(high_sel), .phys_addr(phys_addr), .next_addr(next_addr)
    );

    pagegen_tracker #(.CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst_n(rst_n), .xfer_step(xfer_step), .xfer_chan(xfer_chan),
        .wide_shift(wide_shift), .base_count(base_count),
        .tc_pulse(tc_pulse), .tc_chan(tc_chan)
    );

    // R6: the next address is always one unit away from the current one
    a_r6_step_distance: assert property (@(posedge clk) disable iff (!rst_n)
        (ADDR_W'(next_addr - cur_addr) == ADDR_W'(1)) ||
        (ADDR_W'(cur_addr - next_addr) == ADDR_W'(1)));
endmodule

// File: tb/pagegen_top_tb_top.sv
module pagegen_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_hi_sel = 1'b0;
    logic [2:0]  io_offset = '0;
    logic [7:0]  io_wdata = '0;
    logic [1:0]  xfer_chan = '0;
    logic [15:0] cur_addr = '0;
    logic [7:0]  chan_mode = '0;
    logic        wide_shift = 1'b0;
    logic [15:0] base_count = '0;
    logic        xfer_step = 1'b0;

    logic [7:0]  rd_a, rd_b;
    logic [30:0] phys_a, phys_b;
    logic [15:0] nxt_a, nxt_b;
    logic        tc_a, tc_b;
    logic [1:0]  tcc_a, tcc_b;

    int checks = 0, failures = 0;
    bit done = 0, mon_en = 0;
    logic [2:0] sb_q[$];
    int model_pos[4];

    always #10 clk = ~clk;

    pagegen_top dut_i (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_hi_sel(io_hi_sel),
        .io_offset(io_offset), .io_wdata(io_wdata), .io_rdata(rd_a),
        .xfer_chan(xfer_chan), .cur_addr(cur_addr), .chan_mode(chan_mode),
        .wide_shift(wide_shift), .base_count(base_count), .xfer_step(xfer_step),
        .phys_addr(phys_a), .next_addr(nxt_a), .tc_pulse(tc_a), .tc_chan(tcc_a)
    );

    pagegen_top #(.HIGH_EN(1'b0)) dut_nohi (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_hi_sel(io_hi_sel),
        .io_offset(io_offset), .io_wdata(io_wdata), .io_rdata(rd_b),
        .xfer_chan(xfer_chan), .cur_addr(cur_addr), .chan_mode(chan_mode),
        .wide_shift(wide_shift), .base_count(base_count), .xfer_step(xfer_step),
        .phys_addr(phys_b), .next_addr(nxt_b), .tc_pulse(tc_b), .tc_chan(tcc_b)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic io_write(input logic hi, input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_hi_sel = hi; io_offset = off; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic io_read(input string req, input logic hi, input logic [2:0] off,
                           input logic [7:0] exp_a, input logic [7:0] exp_b);
        @(negedge clk);
        io_hi_sel = hi; io_offset = off;
        #1;
        chk(req, {24'd0, rd_a}, {24'd0, exp_a});
        chk(req, {24'd0, rd_b}, {24'd0, exp_b});
    endtask

    task automatic addr_check(input string req, input logic [1:0] ch, input logic [15:0] cur,
                              input logic [7:0] mode, input logic [30:0] exp_pa,
                              input logic [30:0] exp_pb, input logic [15:0] exp_n);
        @(negedge clk);
        xfer_chan = ch; cur_addr = cur; chan_mode = mode;
        #1;
        chk(req, {1'b0, phys_a}, {1'b0, exp_pa});
        chk(req, {1'b0, phys_b}, {1'b0, exp_pb});
        chk(req, {16'd0, nxt_a}, {16'd0, exp_n});
    endtask

    // Driver: computes the expected terminal count from R7 and queues it.
    task automatic step(input logic [1:0] ch, input logic sh, input logic [15:0] base);
        int np, lim;
        logic t;
        @(negedge clk);
        xfer_chan = ch; wide_shift = sh; base_count = base; xfer_step = 1'b1;
        np  = model_pos[ch] + (1 << sh);
        lim = (int'(base) + 1) << sh;
        t   = (np == lim);
        model_pos[ch] = t ? 0 : np;
        @(posedge clk);
        sb_q.push_back({t, ch});
        @(negedge clk);
        xfer_step = 1'b0;
    endtask

    // Monitor: R7/R8 scoreboard comparison at each falling edge.
    always @(negedge clk) begin
        if (mon_en) begin
            if (sb_q.size() > 0) begin
                logic [2:0] e;
                e = sb_q.pop_front();
                chk("R7 tc_pulse", {31'd0, tc_a}, {31'd0, e[2]});
                if (e[2]) chk("R8 tc_chan", {30'd0, tcc_a}, {30'd0, e[1:0]});
            end else begin
                chk("R8 pulse one clock", {31'd0, tc_a}, 32'd0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) model_pos[i] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1;
        // R9: reset state
        for (int o = 0; o < 8; o++) io_read("R9 reset page", 1'b0, 3'(o), 8'h00, 8'h00);
        chk("R9 tc after reset", {31'd0, tc_a}, 32'd0);

        // R3/R1: low pages through each mapped offset
        io_write(1'b0, 3'd1, 8'h11);
        io_write(1'b0, 3'd2, 8'h22);
        io_write(1'b0, 3'd3, 8'h33);
        io_write(1'b0, 3'd7, 8'h77);
        io_read("R3 low readback", 1'b0, 3'd1, 8'h11, 8'h11);
        io_read("R3 low readback", 1'b0, 3'd7, 8'h77, 8'h77);
        // R1: channel map via the composed address
        addr_check("R1 ch0", 2'd0, 16'h0100, 8'h00, {7'h00, 8'h77, 16'h0100}, {7'h00, 8'h77, 16'h0100}, 16'h0101);
        addr_check("R1 ch1", 2'd1, 16'h0100, 8'h00, {7'h00, 8'h33, 16'h0100}, {7'h00, 8'h33, 16'h0100}, 16'h0101);
        addr_check("R1 ch2", 2'd2, 16'h0100, 8'h00, {7'h00, 8'h11, 16'h0100}, {7'h00, 8'h11, 16'h0100}, 16'h0101);
        addr_check("R1 ch3", 2'd3, 16'h0100, 8'h00, {7'h00, 8'h22, 16'h0100}, {7'h00, 8'h22, 16'h0100}, 16'h0101);

        // R2: unmapped offsets ignore writes and read as zero
        io_write(1'b0, 3'd0, 8'hEE);
        io_write(1'b0, 3'd4, 8'hEE);
        io_write(1'b0, 3'd5, 8'hEE);
        io_write(1'b0, 3'd6, 8'hEE);
        io_read("R2 unmapped read", 1'b0, 3'd0, 8'h00, 8'h00);
        io_read("R2 unmapped read", 1'b0, 3'd5, 8'h00, 8'h00);
        io_read("R2 mapped intact", 1'b0, 3'd1, 8'h11, 8'h11);
        io_read("R2 mapped intact", 1'b0, 3'd2, 8'h22, 8'h22);
        io_read("R2 mapped intact", 1'b0, 3'd3, 8'h33, 8'h33);
        io_read("R2 mapped intact", 1'b0, 3'd7, 8'h77, 8'h77);

        // R4/R5: high pages, bit 7 dropped, disabled bank inert
        io_write(1'b1, 3'd1, 8'hFF);
        io_write(1'b1, 3'd7, 8'h05);
        io_read("R3 high readback / R5 disabled", 1'b1, 3'd1, 8'hFF, 8'h00);
        io_read("R3 high readback / R5 disabled", 1'b1, 3'd7, 8'h05, 8'h00);
        io_read("R5 low unaffected by high write", 1'b0, 3'd1, 8'h11, 8'h11);
        addr_check("R4 bit7 dropped / R5", 2'd2, 16'h1234, 8'h00,
                   {7'h7F, 8'h11, 16'h1234}, {7'h00, 8'h11, 16'h1234}, 16'h1235);
        addr_check("R4 ch0 high", 2'd0, 16'h1234, 8'h00,
                   {7'h05, 8'h77, 16'h1234}, {7'h00, 8'h77, 16'h1234}, 16'h1235);

        // R6: direction from mode bit 5, wrap both ways
        addr_check("R6 down", 2'd1, 16'h1234, 8'h20, {7'h00, 8'h33, 16'h1234}, {7'h00, 8'h33, 16'h1234}, 16'h1233);
        addr_check("R6 up other bits", 2'd1, 16'h1234, 8'hDF, {7'h00, 8'h33, 16'h1234}, {7'h00, 8'h33, 16'h1234}, 16'h1235);
        addr_check("R6 up wrap", 2'd1, 16'hFFFF, 8'h00, {7'h00, 8'h33, 16'hFFFF}, {7'h00, 8'h33, 16'hFFFF}, 16'h0000);
        addr_check("R6 down wrap", 2'd1, 16'h0000, 8'h20, {7'h00, 8'h33, 16'h0000}, {7'h00, 8'h33, 16'h0000}, 16'hFFFF);

        // R7/R8: interleaved channels, both shifts
        step(2'd1, 1'b0, 16'd2);
        step(2'd3, 1'b1, 16'd1);
        step(2'd1, 1'b0, 16'd2);
        step(2'd3, 1'b1, 16'd1);
        step(2'd1, 1'b0, 16'd2);
        for (int k = 0; k < 3; k++) step(2'd1, 1'b0, 16'd2);
        step(2'd0, 1'b1, 16'd0);
        step(2'd2, 1'b0, 16'd0);
        for (int k = 0; k < 4; k++) step(2'd3, 1'b1, 16'd3);
        repeat (3) @(negedge clk);
        chk("R8 queue drained", sb_q.size(), 32'd0);
        mon_en = 0;
        summary();
    end
endmodule